// File: doc/BRIEF.md
# Banked Management Register Window

This block is the register file behind a host-side management port. A host issues single-byte reads and writes over a parallel strobe interface with an 8-bit address and 8-bit data. The serial transport that produces those strobes lives elsewhere. The 256-location window has two parts. The lower part is a common bank that the host always sees. The upper part is steered to one of two physical pages by a single select bit, and that select bit sits in the common bank.

The window holds three kinds of location. Writable locations hold host configuration. A read-only status location reflects live hardware inputs. Every other location is unmapped. A small software-reset register drives a group of reset request outputs directly. Page 1 carries a fourteen-byte packet area: thirteen payload bytes with a checksum slot inside the run. Page 0 carries a scattered set of transmitter control registers.

Top module: `regwin_top`

## Requirements
- R1: After reset, every writable location, the page select, `rst_req_o` and `rdata` are all zero.
- R2: Addresses 0x00 to 0x2F reach the common bank whatever the page select holds. A value written under one page setting reads back unchanged under the other.
- R3: Bit 0 of location 0x0F is the page select. When it is 0, addresses 0x30 to 0xFF reach page 0. When it is 1, they reach page 1. Bits 7:1 of 0x0F read as 0.
- R4: Page 0 and page 1 have separate storage at overlapping offsets. A write at offset 0x61 in one page leaves the same offset in the other page unchanged.
- R5: Location 0x0E is read-only. It reads bit 6 = `hpd_in`, bit 4 = `vid_stable_in` (sampled at the read edge) and all other bits 0. Writes to it have no effect.
- R6: Location 0x04 has writable bits 5, 4, 3, 2 and 0. Bits 7, 6 and 1 read as 0. Its state drives `rst_req_o` = {bit5, bit4, bit3, bit2, bit0} from the edge that writes it.
- R7: Unmapped addresses read 0x00, and writes to them change nothing. Examples are 0x00, 0x2F, 0x80, 0x70 with page 1 selected, and 0x58 with page 0 selected.
- R8: With page 1 selected, offsets 0x58 to 0x65 are fourteen full 8-bit registers. The checksum slot at 0x5D is one of them.
- R9: A read strobe loads `rdata` at the clock edge where it is sampled, and `rdata` holds until the next read. A write becomes visible to a read one cycle later. When a read and a write of the same location fall in the same cycle, the read returns the old value.
- R10: With page 0 selected, offsets 0x61 to 0x64, 0x70, 0xC0, 0xC1, 0xC6 and 0xCD are full 8-bit registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Window address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| hpd_in | input | 1 | Hot-plug detect level |
| vid_stable_in | input | 1 | Transmit video stable level |
| rst_req_o | output | 5 | Reset requests {reference, audio-side, video, audio, content-protection} |

## Verification
The same offsets are written and read under both page settings. This separates a correct page steer from a decoder that ignores the select bit or aliases the two pages. The common bank is crossed between page changes, which catches any paging of the low addresses. Unmapped and read-only addresses get all-ones writes followed by reads, so a decoder that leaks a write into a neighbour or returns stale data shows up. The status inputs take each combination so that each bit's position is pinned. A same-cycle read and write, followed by idle cycles, separates the old value, the new value and the held value.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int AW            = 8;
    localparam int DW            = 8;
    localparam int IDX_W         = 4;
    localparam int COMMON_DEPTH  = 10;
    localparam int PAGE0_DEPTH   = 9;
    localparam int PAGE1_DEPTH   = 14;

    localparam logic [AW-1:0] COMMON_LAST = 8'h2F;
    localparam logic [AW-1:0] RST_ADDR    = 8'h04;
    localparam logic [AW-1:0] STAT_ADDR   = 8'h0E;
    localparam logic [AW-1:0] SEL_ADDR    = 8'h0F;
    localparam logic [AW-1:0] PKT_FIRST   = 8'h58;
    localparam logic [AW-1:0] PKT_LAST    = 8'h65;

    localparam logic [DW-1:0] RST_MASK    = 8'h3D;
    localparam logic [DW-1:0] SEL_MASK    = 8'h01;
    localparam int STAT_HPD_BIT           = 6;
    localparam int STAT_VID_BIT           = 4;

    // index slots inside the common store
    localparam logic [IDX_W-1:0] CIDX_RST = 4'd0;
    localparam logic [IDX_W-1:0] CIDX_SEL = 4'd1;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_COMMON,
        TGT_PAGE0,
        TGT_PAGE1,
        TGT_STATUS
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    wmask;
    } dec_t;

    function automatic dec_t decode_addr(input logic [AW-1:0] a, input logic sel);
        dec_t r;
        r.tgt   = TGT_NONE;
        r.idx   = '0;
        r.wmask = '0;
        if (a <= COMMON_LAST) begin
            if (a == RST_ADDR) begin
                r.tgt = TGT_COMMON; r.idx = CIDX_RST; r.wmask = RST_MASK;
            end else if (a == SEL_ADDR) begin
                r.tgt = TGT_COMMON; r.idx = CIDX_SEL; r.wmask = SEL_MASK;
            end else if (a == STAT_ADDR) begin
                r.tgt = TGT_STATUS;
            end else if (a >= 8'h10 && a <= 8'h15) begin
                r.tgt = TGT_COMMON; r.idx = IDX_W'(a - 8'h0E); r.wmask = '1;
            end else if (a == 8'h1D) begin
                r.tgt = TGT_COMMON; r.idx = 4'd8; r.wmask = '1;
            end else if (a == 8'h1E) begin
                r.tgt = TGT_COMMON; r.idx = 4'd9; r.wmask = '1;
            end
        end else if (!sel) begin
            r.wmask = '1;
            r.tgt   = TGT_PAGE0;
            case (a)
                8'h61:   r.idx = 4'd0;
                8'h62:   r.idx = 4'd1;
                8'h63:   r.idx = 4'd2;
                8'h64:   r.idx = 4'd3;
                8'h70:   r.idx = 4'd4;
                8'hC0:   r.idx = 4'd5;
                8'hC1:   r.idx = 4'd6;
                8'hC6:   r.idx = 4'd7;
                8'hCD:   r.idx = 4'd8;
                default: begin r.tgt = TGT_NONE; r.wmask = '0; end
            endcase
        end else if (a >= PKT_FIRST && a <= PKT_LAST) begin
            r.tgt = TGT_PAGE1; r.idx = IDX_W'(a - PKT_FIRST); r.wmask = '1;
        end
        return r;
    endfunction

endpackage

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] wmask,
    output logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] words [DEPTH]
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= '0;
            else if (we && idx == IDX_W'(i))
                words[i] <= (words[i] & ~wmask) | (wdata & wmask);
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < DEPTH; k++)
            if (idx == IDX_W'(k)) rd_word = words[k];
    end

endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          hpd_in,
    input  logic          vid_stable_in,
    output logic [4:0]    rst_req_o
);

    dec_t          dec;
    logic          page_sel;
    logic [DW-1:0] c_rd, p0_rd, p1_rd, rd_mux, status_word;
    logic [DW-1:0] c_words  [COMMON_DEPTH];
    logic [DW-1:0] p0_words [PAGE0_DEPTH];
    logic [DW-1:0] p1_words [PAGE1_DEPTH];
    logic          unused_bits;

    assign page_sel = c_words[CIDX_SEL][0];
    assign dec      = decode_addr(addr, page_sel);

    regwin_store #(.DEPTH(COMMON_DEPTH), .WIDTH(DW), .IDX_W(IDX_W)) u_common (
        .clk(clk), .rst(rst), .we(wr_en && dec.tgt == TGT_COMMON),
        .idx(dec.idx), .wdata(wdata), .wmask(dec.wmask),
        .rd_word(c_rd), .words(c_words)
    );

    regwin_store #(.DEPTH(PAGE0_DEPTH), .WIDTH(DW), .IDX_W(IDX_W)) u_page0 (
        .clk(clk), .rst(rst), .we(wr_en && dec.tgt == TGT_PAGE0),
        .idx(dec.idx), .wdata(wdata), .wmask(dec.wmask),
        .rd_word(p0_rd), .words(p0_words)
    );

    regwin_store #(.DEPTH(PAGE1_DEPTH), .WIDTH(DW), .IDX_W(IDX_W)) u_page1 (
        .clk(clk), .rst(rst), .we(wr_en && dec.tgt == TGT_PAGE1),
        .idx(dec.idx), .wdata(wdata), .wmask(dec.wmask),
        .rd_word(p1_rd), .words(p1_words)
    );

    always_comb begin
        status_word               = '0;
        status_word[STAT_HPD_BIT] = hpd_in;
        status_word[STAT_VID_BIT] = vid_stable_in;
    end

    always_comb begin
        case (dec.tgt)
            TGT_COMMON: rd_mux = c_rd;
            TGT_PAGE0:  rd_mux = p0_rd;
            TGT_PAGE1:  rd_mux = p1_rd;
            TGT_STATUS: rd_mux = status_word;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign rst_req_o = {c_words[CIDX_RST][5:2], c_words[CIDX_RST][0]};

    assign unused_bits = ^{c_words[CIDX_SEL][7:1], c_words[CIDX_RST][7:6],
                           c_words[CIDX_RST][1], p0_words[0], p1_words[0]};

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       hpd_in,
    input logic       vid_stable_in,
    input logic [4:0] rst_req_o
);

    // R6
    rst_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h04) |=> rst_req_o == $past({wdata[5:2], wdata[0]}));

    // R6
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rst_req_o));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h00) |=> rdata == 8'h00);

    // R5
    status_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h0E) |=>
            (rdata[6] == $past(hpd_in) && rdata[4] == $past(vid_stable_in) &&
             {rdata[7], rdata[5], rdata[3:0]} == 6'b0));

endmodule

bind regwin_top regwin_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .hpd_in(hpd_in),
    .vid_stable_in(vid_stable_in), .rst_req_o(rst_req_o)
);

// File: tb/sim_regwin_top.sv
module sim_regwin_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       hpd_in = 1'b0, vid_stable_in = 1'b0;
    logic [4:0] rst_req_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       seen_rd = 1'b0;
    logic [7:0] pkt_val [14];
    logic [7:0] p0_addr [9];

    always #4 clk = ~clk;

    regwin_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hpd_in(hpd_in),
        .vid_stable_in(vid_stable_in), .rst_req_o(rst_req_o)
    );

    // monitor
    always @(posedge clk) seen_rd <= rd_en && !rst;

    always @(negedge clk) begin
        if (seen_rd) begin
            logic [7:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected read result %h, expected none", "R9", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdwr(input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        addr = a; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk({3'b0, rst_req_o}, 8'h00, "R1");
        chk(rdata, 8'h00, "R1");
        rd(8'h04, 8'h00, "R1");
        rd(8'h0F, 8'h00, "R1");
        rd(8'h10, 8'h00, "R1");
        rd(8'h61, 8'h00, "R1");

        // R6 reset register
        wr(8'h04, 8'hFF);
        chk({3'b0, rst_req_o}, 8'h1F, "R6");
        rd(8'h04, 8'h3D, "R6");
        wr(8'h04, 8'h08);
        chk({3'b0, rst_req_o}, 8'h04, "R6");
        wr(8'h04, 8'h21);
        chk({3'b0, rst_req_o}, 8'h11, "R6");
        wr(8'h04, 8'h00);
        chk({3'b0, rst_req_o}, 8'h00, "R6");

        // R2 / R3 common bank and select
        wr(8'h10, 8'hA5);
        wr(8'h0F, 8'hFF);
        rd(8'h0F, 8'h01, "R3");
        rd(8'h10, 8'hA5, "R2");
        wr(8'h1E, 8'h3C);
        wr(8'h0F, 8'h00);
        rd(8'h1E, 8'h3C, "R2");
        rd(8'h10, 8'hA5, "R2");

        // R4 page isolation at shared offset
        wr(8'h61, 8'h11);
        wr(8'h0F, 8'h01);
        rd(8'h61, 8'h00, "R4");
        wr(8'h61, 8'h22);
        rd(8'h61, 8'h22, "R4");
        wr(8'h0F, 8'h00);
        rd(8'h61, 8'h11, "R4");

        // R8 packet area on page 1
        wr(8'h0F, 8'h01);
        for (int i = 0; i < 14; i++) begin
            pkt_val[i] = 8'(i * 37 + 5);
            wr(8'(8'h58 + i), pkt_val[i]);
        end
        for (int i = 0; i < 14; i++)
            rd(8'(8'h58 + i), pkt_val[i], "R8");

        // R10 page 0 control registers
        wr(8'h0F, 8'h00);
        p0_addr = '{8'h61, 8'h62, 8'h63, 8'h64, 8'h70, 8'hC0, 8'hC1, 8'hC6, 8'hCD};
        for (int i = 0; i < 9; i++) wr(p0_addr[i], 8'(8'hF0 - i * 11));
        for (int i = 0; i < 9; i++) rd(p0_addr[i], 8'(8'hF0 - i * 11), "R10");

        // R5 status register
        hpd_in = 1'b1; vid_stable_in = 1'b0;
        rd(8'h0E, 8'h40, "R5");
        hpd_in = 1'b0; vid_stable_in = 1'b1;
        rd(8'h0E, 8'h10, "R5");
        hpd_in = 1'b1;
        rd(8'h0E, 8'h50, "R5");
        hpd_in = 1'b0; vid_stable_in = 1'b0;
        wr(8'h0E, 8'hFF);
        rd(8'h0E, 8'h00, "R5");

        // R7 unmapped locations
        wr(8'h00, 8'hFF);
        rd(8'h00, 8'h00, "R7");
        wr(8'h2F, 8'hFF);
        rd(8'h2F, 8'h00, "R7");
        wr(8'h80, 8'hFF);
        rd(8'h80, 8'h00, "R7");
        wr(8'h58, 8'hEE);
        wr(8'h0F, 8'h01);
        rd(8'h58, pkt_val[0], "R7");
        wr(8'h70, 8'h99);
        rd(8'h70, 8'h00, "R7");
        wr(8'h0F, 8'h00);
        rd(8'h70, 8'(8'hF0 - 4 * 11), "R7");
        chk({3'b0, rst_req_o}, 8'h00, "R7");

        // R9 timing: same-cycle read/write, hold
        wr(8'h11, 8'h55);
        rdwr(8'h11, 8'h66, 8'h55, "R9");
        rd(8'h11, 8'h66, "R9");
        repeat (3) @(negedge clk);
        chk(rdata, 8'h66, "R9");

        repeat (2) @(negedge clk);
        chk(8'(exp_q.size()), 8'h00, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule